// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Programmable Level Flags

This block is a first-in first-out buffer for 18-bit words with a write port and a read port, each on its own clock. The two clocks may be one and the same net or may run at unrelated frequencies. Pointers cross between the two domains in Gray code through two-flop synchronizers, so each side sees the other's progress a few of its own cycles late and always errs on the safe side.

Two read timings are offered, chosen by a mode input that is held steady while reset is active. In standard timing the output register changes only when a read is accepted, so the first word written into an empty buffer stays hidden until it is explicitly read. In fall-through timing the head word is moved into the output register on its own. The read flag then means "no word presented" and a read consumes the word on display. The output register counts as one extra storage slot in this timing. The level flags are almost-empty, half-full and almost-full, and the almost thresholds can be changed at run time. The standard-timing empty flag and the full flag can be released one cycle later through an extra register stage, for consumers that re-register them.

Both domains share one synchronous active-high reset. It must be held for at least four edges of the slower clock. Threshold loading and mode changes are meant to happen while the buffer is idle.

Top module: `dual_mode_fifo`

## Requirements
- R1: Words are 18 bits and DEPTH is one of 256, 512, 1024 or 4096. A word is stored on each write-clock rising edge where `wr_en` is 1, `ld_off` is 0 and `wr_flag` is 0. Words leave in the order they were written, whatever the ratio of the two clocks.
- R2: A write attempted while the buffer holds its full capacity is dropped. The write pointer does not move and the dropped word never reaches the read side.
- R3: In standard timing, a read attempted while the buffer is empty is dropped. `rd_data` keeps its last value and the read pointer does not move.
- R4: In standard timing, `rd_data` is 0 after reset and changes only on the read-clock edge that accepts a read. That edge loads the oldest stored word. Words written without a read never appear on the output.
- R5: In fall-through timing, a word written into an empty buffer appears on `rd_data` after the third read-clock rising edge that follows its write edge, and `rd_flag` falls at the same time, with no read needed. The word then stays until a read with `rd_flag` low consumes it.
- R6: `rd_flag` = 1 means empty in standard timing and no word presented in fall-through timing. `wr_flag` = 1 means full / not ready to accept. After reset `rd_flag` is 1 and `wr_flag` is 0.
- R7: With `flag_dbl` = 0, the standard-timing `rd_flag` falls after the third read-clock edge following a write into an empty buffer. With `flag_dbl` = 1 it falls after the fourth. In both settings the read that empties the buffer, and the write that fills it, raise the flag on that same edge.
- R8: `half_full` is 1 exactly when the write-side count of stored words is greater than DEPTH/2.
- R9: `almost_empty` is 1 when the read-side count is at most the low threshold. `almost_full` is 1 when the write-side count is at least DEPTH minus the high threshold.
- R10: While `ld_off` is 1, the first write-enabled cycle loads the low threshold from `wr_data[log2(DEPTH)-1:0]` and the second loads the high threshold. Further cycles alternate between the two. No data is stored on these cycles, and dropping `ld_off` points the next load back at the low threshold.
- R11: When `oe` is 0, `rd_data` is all zeros and `rd_bus_en` is 0. Neither changes the buffer contents, and raising `oe` shows the held word again.
- R12: Reset empties the buffer and sets both thresholds to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| fwft_mode | input | 1 | 1 selects fall-through read timing, 0 standard timing |
| flag_dbl | input | 1 | 1 adds the extra release stage to the empty and full flags |
| wr_en | input | 1 | Write request |
| ld_off | input | 1 | Threshold-load mode for write-enabled cycles |
| wr_data | input | 18 | Write word, or threshold value while loading |
| wr_flag | output | 1 | Full / not ready to accept |
| half_full | output | 1 | More than half of DEPTH stored |
| almost_full | output | 1 | Write-side count at or above the high mark |
| rd_en | input | 1 | Read request |
| oe | input | 1 | Output enable for the read bus |
| rd_data | output | 18 | Read word, zero while `oe` is 0 |
| rd_bus_en | output | 1 | Read bus is driven |
| rd_flag | output | 1 | Empty / no word presented |
| almost_empty | output | 1 | Read-side count at or below the low mark |

## Verification
A pointer that moves on a dropped access shows up at the read port as a duplicated, skipped or foreign word in the sequence. The scoreboard catches this on the first affected read, and it reveals a stale or lost word as soon as the buffer is drained. A wrong synchronizer depth or flag stage shifts the edge on which `rd_flag` falls, and that is measured exactly by counting read-clock edges after a single write. Threshold or count errors show up as a level flag on the wrong side of a boundary word count once both domains have settled.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int DATA_W      = 18;
    localparam int PTR_MAX     = 13;
    localparam int OFF_DEFAULT = 7;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [PTR_MAX-1:0] ptr_t;

    typedef enum logic {SEL_LOW = 1'b0, SEL_HIGH = 1'b1} off_sel_e;

    typedef struct packed {
        logic full;
        logic half;
        logic almost_full;
    } wr_stat_t;

    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t from_gray(ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/sfifo_sync2.sv
module sfifo_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sfifo_wr_ctl.sv
module sfifo_wr_ctl
    import sfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          ld,
    input  logic          dbl,
    input  logic [AW-1:0] off_data,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] level,
    output logic          full_int,
    output wr_stat_t      stat,
    output logic [AW-1:0] low_off
);
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wbin_nxt;
    logic [AW-1:0] high_off;
    logic          full_d;
    off_sel_e      sel;

    always_comb begin
        rbin_s   = PW'(from_gray(PTR_MAX'(rgray_s)));
        mem_we   = wr_en && !ld && !full_int;
        mem_addr = wbin[AW-1:0];
        wbin_nxt = wbin + PW'(mem_we);
        level    = wbin - rbin_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin     <= '0;
            wgray    <= '0;
            full_int <= 1'b0;
            full_d   <= 1'b0;
            sel      <= SEL_LOW;
            low_off  <= AW'(OFF_DEFAULT);
            high_off <= AW'(OFF_DEFAULT);
        end else begin
            wbin     <= wbin_nxt;
            wgray    <= PW'(to_gray(PTR_MAX'(wbin_nxt)));
            full_int <= (wbin_nxt - rbin_s) == PW'(DEPTH);
            full_d   <= full_int;
            if (ld) begin
                if (wr_en) begin
                    if (sel == SEL_LOW) low_off  <= off_data;
                    else                high_off <= off_data;
                    sel <= (sel == SEL_LOW) ? SEL_HIGH : SEL_LOW;
                end
            end else begin
                sel <= SEL_LOW;
            end
        end
    end

    always_comb begin
        stat.full        = dbl ? (full_int | full_d) : full_int;
        stat.half        = level > PW'(DEPTH / 2);
        stat.almost_full = level >= (PW'(DEPTH) - PW'(high_off));
    end
endmodule

// File: rtl/sfifo_rd_ctl.sv
module sfifo_rd_ctl
    import sfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft,
    input  logic          dbl,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] low_off,
    input  word_t         mem_q,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          empty_int,
    output word_t         q,
    output logic          rd_flag,
    output logic          almost_empty
);
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rbin_nxt;
    logic          avail;
    logic          fetch;
    logic          valid;
    logic          empty_d;

    always_comb begin
        wbin_s   = PW'(from_gray(PTR_MAX'(wgray_s)));
        avail    = wbin_s != rbin;
        fetch    = fwft ? (avail && (!valid || rd_en)) : (rd_en && !empty_int);
        rbin_nxt = rbin + PW'(fetch);
        mem_addr = rbin[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin      <= '0;
            rgray     <= '0;
            empty_int <= 1'b1;
            empty_d   <= 1'b1;
            valid     <= 1'b0;
            q         <= '0;
        end else begin
            rbin      <= rbin_nxt;
            rgray     <= PW'(to_gray(PTR_MAX'(rbin_nxt)));
            empty_int <= wbin_s == rbin_nxt;
            empty_d   <= empty_int;
            if (fetch) begin
                q     <= mem_q;
                valid <= 1'b1;
            end else if (fwft && rd_en) begin
                valid <= 1'b0;
            end
        end
    end

    always_comb begin
        if (fwft)     rd_flag = !valid;
        else if (dbl) rd_flag = empty_int | empty_d;
        else          rd_flag = empty_int;
        almost_empty = (wbin_s - rbin) <= PW'(low_off);
    end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import sfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              fwft_mode,
    input  logic              flag_dbl,
    input  logic              wr_en,
    input  logic              ld_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_full,
    input  logic              rd_en,
    input  logic              oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bus_en,
    output logic              rd_flag,
    output logic              almost_empty
);
    word_t         store [DEPTH];
    logic [PW-1:0] w_bin, w_gray, w_gray_s, w_level;
    logic [PW-1:0] r_bin, r_gray, r_gray_s;
    logic [AW-1:0] w_addr, r_addr, low_off;
    logic          w_we, w_full, r_empty;
    wr_stat_t      w_stat;
    word_t         mem_q, q_int;

    sfifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en), .ld(ld_off), .dbl(flag_dbl),
        .off_data(wr_data[AW-1:0]), .rgray_s(r_gray_s), .wbin(w_bin),
        .wgray(w_gray), .mem_we(w_we), .mem_addr(w_addr), .level(w_level),
        .full_int(w_full), .stat(w_stat), .low_off(low_off)
    );

    sfifo_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(w_gray), .q(w_gray_s));
    sfifo_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .d(r_gray), .q(r_gray_s));

    sfifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst(rst), .fwft(fwft_mode), .dbl(flag_dbl), .rd_en(rd_en),
        .wgray_s(w_gray_s), .low_off(low_off), .mem_q(mem_q), .mem_addr(r_addr),
        .rbin(r_bin), .rgray(r_gray), .empty_int(r_empty), .q(q_int),
        .rd_flag(rd_flag), .almost_empty(almost_empty)
    );

    always_ff @(posedge wr_clk) begin
        if (w_we) store[w_addr] <= wr_data;
    end

    always_comb begin
        mem_q       = store[r_addr];
        wr_flag     = w_stat.full;
        half_full   = w_stat.half;
        almost_full = w_stat.almost_full;
        rd_data     = oe ? q_int : '0;
        rd_bus_en   = oe;
    end
endmodule

module sfifo_chk #(
    parameter  int DEPTH = 256,
    localparam int PW    = $clog2(DEPTH) + 1
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic          fwft_mode,
    input logic          wr_en,
    input logic          ld_off,
    input logic          rd_en,
    input logic          rd_flag,
    input logic          w_full,
    input logic          r_empty,
    input logic [PW-1:0] w_bin,
    input logic [PW-1:0] r_bin,
    input logic [PW-1:0] w_level,
    input logic [17:0]   q_int
);
    // R2
    full_hold_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (w_full && wr_en) |=> $stable(w_bin));
    // R2
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
        w_level <= PW'(DEPTH));
    // R10
    load_nostore_chk: assert property (@(posedge wr_clk) disable iff (rst)
        ld_off |=> $stable(w_bin));
    // R3
    empty_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (!fwft_mode && r_empty && rd_en) |=> ($stable(r_bin) && $stable(q_int)));
    // R4
    std_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (!fwft_mode && !rd_en) |=> $stable(q_int));
    // R5
    fwft_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (fwft_mode && !rd_flag && !rd_en) |=> ($stable(q_int) && !rd_flag));
endmodule

bind dual_mode_fifo sfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .ld_off(ld_off), .rd_en(rd_en), .rd_flag(rd_flag),
    .w_full(w_full), .r_empty(r_empty), .w_bin(w_bin), .r_bin(r_bin),
    .w_level(w_level), .q_int(q_int)
);

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;
    import sfifo_pkg::*;

    localparam int DEPTH       = 256;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;

    logic  wr_clk, rd_clk, rst, fwft_mode, flag_dbl, wr_en, ld_off, rd_en, oe;
    word_t wr_data, rd_data;
    logic  wr_flag, half_full, almost_full, rd_bus_en, rd_flag, almost_empty;

    dual_mode_fifo #(.DEPTH(DEPTH)) i_dual_mode_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .fwft_mode(fwft_mode),
        .flag_dbl(flag_dbl), .wr_en(wr_en), .ld_off(ld_off), .wr_data(wr_data),
        .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full),
        .rd_en(rd_en), .oe(oe), .rd_data(rd_data), .rd_bus_en(rd_bus_en),
        .rd_flag(rd_flag), .almost_empty(almost_empty)
    );

    initial begin
        wr_clk = 1'b0;
        forever #(WCLK_PERIOD / 2) wr_clk = ~wr_clk;
    end
    initial begin
        rd_clk = 1'b0;
        #1;
        forever #(RCLK_PERIOD / 2) rd_clk = ~rd_clk;
    end

    int    n_checks = 0;
    int    n_fail   = 0;
    int    rd_edges = 0;
    int    seq      = 0;
    bit    std_pending = 1'b0;
    bit    writer_done = 1'b1;
    bit    done        = 1'b0;
    word_t last_seen   = '0;
    word_t exp_q[$];

    always @(posedge rd_clk) rd_edges++;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sb_compare();
        word_t e;
        if (exp_q.size() == 0) begin
            check("R1", "read with no expected word", 32'(rd_data), 32'hFFFFFFFF);
        end else begin
            e = exp_q.pop_front();
            check("R1", "scoreboard word", 32'(rd_data), 32'(e));
        end
        last_seen = rd_data;
    endtask

    // scoreboard monitor
    always @(negedge rd_clk) begin
        if (!rst) begin
            if (std_pending) begin
                sb_compare();
                std_pending = 1'b0;
            end
            if (rd_en && !rd_flag) begin
                if (fwft_mode) sb_compare();
                else           std_pending = 1'b1;
            end
        end
    end

    function automatic word_t pattern(input int s);
        return word_t'(18'h2A5A5 ^ (s * 37));
    endfunction

    task automatic do_reset(input logic fwft, input logic dbl);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; ld_off = 1'b0;
        fwft_mode = fwft; flag_dbl = dbl;
        repeat (6) @(posedge rd_clk);
        #1;
        exp_q.delete();
        std_pending = 1'b0;
        rst = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(posedge rd_clk);
        #1;
    endtask

    task automatic wr_stream(input int n, input bit gappy);
        int         sent = 0;
        logic [7:0] lf   = 8'h5A;
        while (sent < n) begin
            @(posedge wr_clk);
            #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (!wr_flag && (!gappy || lf[0])) begin
                wr_en   = 1'b1;
                wr_data = pattern(seq);
                exp_q.push_back(wr_data);
                seq++;
                sent++;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(posedge wr_clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_until_empty(input bit gappy);
        logic [7:0] lf = 8'hC3;
        for (int i = 0; i < 40000; i++) begin
            @(posedge rd_clk);
            #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (writer_done && exp_q.size() == 0 && !std_pending) break;
            rd_en = !rd_flag && (!gappy || lf[1]);
        end
        rd_en = 1'b0;
        settle();
        check("R1", "all written words read back", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic lag_after_write(input word_t d, output int lag);
        int e0;
        @(posedge wr_clk);
        #1;
        wr_en = 1'b1; wr_data = d; exp_q.push_back(d);
        @(posedge wr_clk);
        e0 = rd_edges;
        #1;
        wr_en = 1'b0;
        lag = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge rd_clk);
            if (!rd_flag) begin
                lag = rd_edges - e0;
                break;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(WCLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lag;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; ld_off = 1'b0; oe = 1'b1;
        wr_data = '0; fwft_mode = 1'b0; flag_dbl = 1'b0;
        do_reset(1'b0, 1'b0);

        // R6 / R12 reset state
        check("R6", "rd_flag after reset", 32'(rd_flag), 32'd1);
        check("R6", "wr_flag after reset", 32'(wr_flag), 32'd0);
        check("R12", "almost_empty after reset", 32'(almost_empty), 32'd1);
        check("R12", "almost_full after reset", 32'(almost_full), 32'd0);
        check("R8", "half_full after reset", 32'(half_full), 32'd0);
        check("R4", "rd_data after reset", 32'(rd_data), 32'd0);
        check("R11", "rd_bus_en with oe", 32'(rd_bus_en), 32'd1);

        // R4: words stay hidden without a read
        wr_stream(3, 1'b0);
        settle();
        check("R4", "output before any read", 32'(rd_data), 32'd0);
        check("R6", "rd_flag with data", 32'(rd_flag), 32'd0);
        check("R9", "almost_empty at 3 words", 32'(almost_empty), 32'd1);
        rd_until_empty(1'b0);
        check("R6", "rd_flag after drain", 32'(rd_flag), 32'd1);

        // R3: reads on empty are dropped
        rd_en = 1'b1;
        repeat (3) @(posedge rd_clk);
        #1;
        rd_en = 1'b0;
        settle();
        check("R3", "rd_data held on empty read", 32'(rd_data), 32'(last_seen));
        check("R3", "rd_flag stays empty", 32'(rd_flag), 32'd1);
        wr_stream(1, 1'b0);
        rd_until_empty(1'b0);

        // R8 / R9 boundaries with default thresholds, R2 full
        wr_stream(7, 1'b0);   settle();
        check("R9", "almost_empty at 7", 32'(almost_empty), 32'd1);
        wr_stream(1, 1'b0);   settle();
        check("R9", "almost_empty at 8", 32'(almost_empty), 32'd0);
        wr_stream(120, 1'b0); settle();
        check("R8", "half_full at 128", 32'(half_full), 32'd0);
        wr_stream(1, 1'b0);   settle();
        check("R8", "half_full at 129", 32'(half_full), 32'd1);
        wr_stream(119, 1'b0); settle();
        check("R9", "almost_full at 248", 32'(almost_full), 32'd0);
        wr_stream(1, 1'b0);   settle();
        check("R9", "almost_full at 249", 32'(almost_full), 32'd1);
        wr_stream(7, 1'b0);   settle();
        check("R6", "wr_flag at capacity", 32'(wr_flag), 32'd1);
        @(posedge wr_clk);
        #1;
        wr_en = 1'b1; wr_data = 18'h3FFFF;
        @(posedge wr_clk);
        #1;
        wr_en = 1'b0;
        check("R2", "wr_flag after dropped write", 32'(wr_flag), 32'd1);
        rd_until_empty(1'b0);
        check("R2", "dropped word absent", 32'(rd_flag), 32'd1);

        // R11 output enable
        wr_stream(1, 1'b0);
        rd_until_empty(1'b0);
        oe = 1'b0;
        #1;
        check("R11", "rd_data gated", 32'(rd_data), 32'd0);
        check("R11", "rd_bus_en low", 32'(rd_bus_en), 32'd0);
        oe = 1'b1;
        #1;
        check("R11", "held word after oe", 32'(rd_data), 32'(last_seen));

        // R10 threshold load: low = 20, high = 30
        @(posedge wr_clk);
        #1;
        ld_off = 1'b1; wr_en = 1'b1; wr_data = 18'd20;
        @(posedge wr_clk);
        #1;
        wr_data = 18'd30;
        @(posedge wr_clk);
        #1;
        wr_en = 1'b0; ld_off = 1'b0;
        settle();
        check("R10", "load cycles store nothing", 32'(rd_flag), 32'd1);
        wr_stream(20, 1'b0);  settle();
        check("R10", "almost_empty at 20", 32'(almost_empty), 32'd1);
        wr_stream(1, 1'b0);   settle();
        check("R10", "almost_empty at 21", 32'(almost_empty), 32'd0);
        wr_stream(204, 1'b0); settle();
        check("R10", "almost_full at 225", 32'(almost_full), 32'd0);
        wr_stream(1, 1'b0);   settle();
        check("R10", "almost_full at 226", 32'(almost_full), 32'd1);
        rd_until_empty(1'b0);

        // R12 reset restores defaults
        do_reset(1'b0, 1'b0);
        wr_stream(8, 1'b0);   settle();
        check("R12", "almost_empty at 8 after reset", 32'(almost_empty), 32'd0);
        wr_stream(240, 1'b0); settle();
        check("R12", "almost_full at 248 after reset", 32'(almost_full), 32'd0);
        rd_until_empty(1'b0);

        // R7 flag release stages
        do_reset(1'b0, 1'b0);
        lag_after_write(18'h1234, lag);
        check("R7", "single-stage empty release edges", 32'(lag), 32'd3);
        rd_until_empty(1'b0);
        do_reset(1'b0, 1'b1);
        lag_after_write(18'h2345, lag);
        check("R7", "double-stage empty release edges", 32'(lag), 32'd4);
        rd_until_empty(1'b0);
        check("R7", "rd_flag up after last read", 32'(rd_flag), 32'd1);

        // R5 fall-through timing
        do_reset(1'b1, 1'b0);
        check("R6", "not-ready after reset in fall-through", 32'(rd_flag), 32'd1);
        lag_after_write(18'h3ACE1, lag);
        check("R5", "fall-through edges", 32'(lag), 32'd3);
        check("R5", "word presented without read", 32'(rd_data), 32'h3ACE1);
        settle();
        check("R5", "word held until read", 32'(rd_data), 32'h3ACE1);
        check("R5", "ready held until read", 32'(rd_flag), 32'd0);
        rd_until_empty(1'b0);
        check("R5", "not-ready after consume", 32'(rd_flag), 32'd1);

        // R1 / R2 streaming with full back-pressure, fall-through
        writer_done = 1'b0;
        fork
            begin wr_stream(600, 1'b1); writer_done = 1'b1; end
            rd_until_empty(1'b1);
        join

        // R1 streaming in standard timing with double-stage flags
        do_reset(1'b0, 1'b1);
        writer_done = 1'b0;
        fork
            begin wr_stream(600, 1'b0); writer_done = 1'b1; end
            rd_until_empty(1'b1);
        join

        finish_run();
    end
endmodule